// File: doc/BRIEF.md
# Parallel Flash Word Program and Erase Engine

This block sits on the host side of a parallel NOR-style flash device and carries out one program or one erase per request. A request (a word write or an erase of the main region, with an address and a data word) is taken on a ready/valid handshake. The engine then drives the fixed unlock write sequence on a simple synchronous flash bus. Every write strobe lasts a set number of clock cycles. After the last command write the engine reads the device back-to-back until it reports that the operation has finished.

Completion is found from the device status. One way is to watch bit 6 until it stops changing between two reads. For a word program, the engine can instead wait until bit 7 at the programmed address matches the written data. A word program ends with one verify read, which compares the stored word with the requested one. If the device never settles within a bounded number of polls, the engine reports a timeout and becomes free for the next request.

The flash bus is synchronous. On a write, `fl_addr` and `fl_wdata` are valid while `fl_we` is high. On a read, `fl_rdata` is sampled at the clock edge that ends each cycle in which `fl_re` is high.

Top module: `flash_word_prog`

## Requirements
- R1: With `req_erase`=0, the engine issues exactly four writes, in this order: 5555h/00AAh, 2AAAh/0055h, 5555h/00A0h, then the request address with the request data.
- R2: With `req_erase`=1, the engine issues exactly six writes, in this order: 5555h/00AAh, 2AAAh/0055h, 5555h/0080h, 5555h/00AAh, 2AAAh/0055h, 5555h/0030h.
- R3: During each write, `fl_we` is high for exactly STROBE_CYC consecutive cycles, and `fl_addr` and `fl_wdata` stay constant for that whole strobe. Between two writes `fl_we` is low for at least one cycle.
- R4: In toggle mode, polling reads start after the final write and repeat every cycle. The operation counts as complete only when two consecutive reads return the same value in bit 6, and never while the device still reports busy.
- R5: With `req_dpoll`=1, a program counts as complete when bit 7 of a read equals bit 7 of the request data. For a program, all poll reads and the verify read use the request address. For an erase, poll reads also use the request address.
- R6: An erase always uses the bit 6 toggle rule, whatever the value of `req_dpoll`.
- R7: If POLL_LIMIT poll reads pass without completion, `err_timeout` pulses for one cycle, `done` stays low, and the engine returns to idle.
- R8: After a program completes, the engine makes one verify read. `done` then pulses for one cycle, and `err_mismatch` is high in that same cycle exactly when the word read differs from `req_data`. An erase finishes with `err_mismatch` low.
- R9: A request is accepted at a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low from the next cycle until the cycle in which `done` or `err_timeout` pulses, and it is high again in that cycle.
- R10: While `rst_n` is low, and at once when it falls mid-operation, `req_ready` is high, `fl_we`, `fl_re`, `done`, `err_timeout` and `err_mismatch` are low, and any operation in flight is abandoned.
- R11: `fl_we` and `fl_re` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_erase | input | 1 | 1 = erase the main region, 0 = program one word |
| req_dpoll | input | 1 | 1 = use bit 7 data polling for program completion |
| req_addr | input | ADDR_W | Target word address |
| req_data | input | DATA_W | Word to program |
| done | output | 1 | One-cycle pulse: operation finished |
| err_timeout | output | 1 | One-cycle pulse: poll limit reached |
| err_mismatch | output | 1 | With `done`: verify read differed from request data |
| fl_addr | output | ADDR_W | Flash bus address |
| fl_wdata | output | DATA_W | Flash bus write data |
| fl_we | output | 1 | Flash write strobe |
| fl_re | output | 1 | Flash read strobe |
| fl_rdata | input | DATA_W | Flash read data, sampled at the end of a read cycle |

## Verification
The bench uses a device model that stays busy for a set number of reads, and tries each request against a few different status patterns. Some busy patterns toggle bit 6 while holding bit 7 away from the data, and others hold bit 6 steady. This separates the toggle rule from the data-poll rule: a design that applies the wrong rule finishes while the model is still busy. For an erase requested with data polling, the model returns a matching bit 7 while bit 6 toggles, which exposes an erase that does not use the toggle rule. A model that never finishes gives the exact poll count for the timeout. A corrupted final word tells a verify read apart from a missing one, and a zero-length busy period covers completion on the first possible read.

// File: rtl/flprog_pkg.sv
package flprog_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STROBE,
        ST_GAP,
        ST_POLL,
        ST_CHECK
    } fsm_t;

    localparam int unsigned STEP_W = 3;

endpackage

// File: rtl/flprog_cmd.sv
module flprog_cmd #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned STEP_W = 3
) (
    input  logic              is_erase,
    input  logic [STEP_W-1:0] step,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic [DATA_W-1:0] tgt_data,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_data,
    output logic              cmd_last
);
    localparam logic [ADDR_W-1:0] UNLOCK_HI = ADDR_W'(16'h5555);
    localparam logic [ADDR_W-1:0] UNLOCK_LO = ADDR_W'(16'h2AAA);
    localparam logic [DATA_W-1:0] KEY_A     = DATA_W'(8'hAA);
    localparam logic [DATA_W-1:0] KEY_B     = DATA_W'(8'h55);
    localparam logic [DATA_W-1:0] OP_PROG   = DATA_W'(8'hA0);
    localparam logic [DATA_W-1:0] OP_ERSETUP = DATA_W'(8'h80);
    localparam logic [DATA_W-1:0] OP_MAINERS = DATA_W'(8'h30);
    localparam logic [STEP_W-1:0] LAST_PROG  = STEP_W'(3);
    localparam logic [STEP_W-1:0] LAST_ERASE = STEP_W'(5);

    always_comb begin
        cmd_addr = UNLOCK_HI;
        cmd_data = KEY_A;
        case (step)
            STEP_W'(0): begin cmd_addr = UNLOCK_HI; cmd_data = KEY_A; end
            STEP_W'(1): begin cmd_addr = UNLOCK_LO; cmd_data = KEY_B; end
            STEP_W'(2): begin
                cmd_addr = UNLOCK_HI;
                cmd_data = is_erase ? OP_ERSETUP : OP_PROG;
            end
            STEP_W'(3): begin
                cmd_addr = is_erase ? UNLOCK_HI : tgt_addr;
                cmd_data = is_erase ? KEY_A : tgt_data;
            end
            STEP_W'(4): begin cmd_addr = UNLOCK_LO; cmd_data = KEY_B; end
            STEP_W'(5): begin cmd_addr = UNLOCK_HI; cmd_data = OP_MAINERS; end
            default:    begin cmd_addr = UNLOCK_HI; cmd_data = KEY_A; end
        endcase
        cmd_last = (step == (is_erase ? LAST_ERASE : LAST_PROG));
    end

endmodule

// File: rtl/flprog_done_det.sv
module flprog_done_det #(
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned TOG_BIT  = 6,
    parameter int unsigned POLL_BIT = 7
) (
    input  logic              use_dpoll,
    input  logic [DATA_W-1:0] rdata,
    input  logic              have_prev,
    input  logic              prev_tog,
    input  logic              tgt_poll_bit,
    output logic              complete
);
    logic tog_settled;
    logic poll_match;

    always_comb begin
        tog_settled = have_prev && (rdata[TOG_BIT] == prev_tog);
        poll_match  = (rdata[POLL_BIT] == tgt_poll_bit);
        complete    = use_dpoll ? poll_match : tog_settled;
    end

endmodule

// File: rtl/flash_word_prog.sv
module flash_word_prog
    import flprog_pkg::*;
#(
    parameter int unsigned ADDR_W     = 16,
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned STROBE_CYC = 3,
    parameter int unsigned POLL_LIMIT = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_erase,
    input  logic              req_dpoll,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              done,
    output logic              err_timeout,
    output logic              err_mismatch,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [DATA_W-1:0] fl_wdata,
    output logic              fl_we,
    output logic              fl_re,
    input  logic [DATA_W-1:0] fl_rdata
);
    localparam int unsigned STRB_W   = $clog2(STROBE_CYC + 1);
    localparam int unsigned POLL_W   = $clog2(POLL_LIMIT + 1);
    localparam int unsigned TOG_BIT  = 6;
    localparam int unsigned POLL_BIT = 7;
    localparam logic [STRB_W-1:0] STRB_END = STRB_W'(STROBE_CYC - 1);
    localparam logic [POLL_W-1:0] POLL_END = POLL_W'(POLL_LIMIT - 1);

    typedef struct packed {
        fsm_t              st;
        logic              erase;
        logic              dpoll;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [STEP_W-1:0] step;
        logic [STRB_W-1:0] scnt;
        logic [POLL_W-1:0] pcnt;
        logic              have_prev;
        logic              prev_tog;
        logic              done;
        logic              tmo;
        logic              mis;
    } regs_t;

    regs_t q, d;

    logic [ADDR_W-1:0] cmd_addr;
    logic [DATA_W-1:0] cmd_data;
    logic              cmd_last;
    logic              complete;

    flprog_cmd #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .STEP_W (STEP_W)
    ) u_cmd (
        .is_erase (q.erase),
        .step     (q.step),
        .tgt_addr (q.addr),
        .tgt_data (q.data),
        .cmd_addr (cmd_addr),
        .cmd_data (cmd_data),
        .cmd_last (cmd_last)
    );

    flprog_done_det #(
        .DATA_W   (DATA_W),
        .TOG_BIT  (TOG_BIT),
        .POLL_BIT (POLL_BIT)
    ) u_det (
        .use_dpoll    (q.dpoll && !q.erase),
        .rdata        (fl_rdata),
        .have_prev    (q.have_prev),
        .prev_tog     (q.prev_tog),
        .tgt_poll_bit (q.data[POLL_BIT]),
        .complete     (complete)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.tmo  = 1'b0;
        d.mis  = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.st    = ST_STROBE;
                    d.erase = req_erase;
                    d.dpoll = req_dpoll;
                    d.addr  = req_addr;
                    d.data  = req_data;
                    d.step  = '0;
                    d.scnt  = '0;
                end
            end
            ST_STROBE: begin
                if (q.scnt == STRB_END) begin
                    d.st   = ST_GAP;
                    d.scnt = '0;
                end else begin
                    d.scnt = q.scnt + 1'b1;
                end
            end
            ST_GAP: begin
                if (cmd_last) begin
                    d.st        = ST_POLL;
                    d.pcnt      = '0;
                    d.have_prev = 1'b0;
                end else begin
                    d.st   = ST_STROBE;
                    d.step = q.step + 1'b1;
                end
            end
            ST_POLL: begin
                d.have_prev = 1'b1;
                d.prev_tog  = fl_rdata[TOG_BIT];
                if (complete) begin
                    if (q.erase) begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                    end else begin
                        d.st = ST_CHECK;
                    end
                end else if (q.pcnt == POLL_END) begin
                    d.st  = ST_IDLE;
                    d.tmo = 1'b1;
                end else begin
                    d.pcnt = q.pcnt + 1'b1;
                end
            end
            ST_CHECK: begin
                d.st   = ST_IDLE;
                d.done = 1'b1;
                d.mis  = (fl_rdata != q.data);
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        req_ready    = (q.st == ST_IDLE);
        fl_we        = (q.st == ST_STROBE);
        fl_re        = (q.st == ST_POLL) || (q.st == ST_CHECK);
        fl_addr      = ((q.st == ST_STROBE) || (q.st == ST_GAP)) ? cmd_addr : q.addr;
        fl_wdata     = cmd_data;
        done         = q.done;
        err_timeout  = q.tmo;
        err_mismatch = q.mis;
    end

    // R11: the bus never reads and writes at once
    a_r11_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_we && fl_re));

    // R3: address and data stay put while the strobe is held
    a_r3_hold_during_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_we && $past(fl_we)) |-> ($stable(fl_addr) && $stable(fl_wdata)));

    // R4: reads begin only after the write strobe has dropped
    a_r4_read_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_re) |-> $past(!fl_we));

    // R9: ready returns only together with a result pulse
    a_r9_ready_rise_with_result: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_ready) |-> (done || err_timeout));

    // R9: an accepted request takes ready low
    a_r9_ready_drop_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R7: one outcome per operation
    a_r7_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err_timeout));

    // R8: mismatch is only reported with done
    a_r8_mismatch_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        err_mismatch |-> done);

endmodule

// File: tb/sim_flash_word_prog.sv
module sim_flash_word_prog;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int STRB = 3;
    localparam int PLIM = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_erase = 1'b0;
    logic          req_dpoll = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic          done, err_timeout, err_mismatch;
    logic [AW-1:0] fl_addr;
    logic [DW-1:0] fl_wdata;
    logic          fl_we, fl_re;
    logic [DW-1:0] fl_rdata;

    flash_word_prog #(
        .ADDR_W(AW), .DATA_W(DW), .STROBE_CYC(STRB), .POLL_LIMIT(PLIM)
    ) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_erase(req_erase), .req_dpoll(req_dpoll),
        .req_addr(req_addr), .req_data(req_data),
        .done(done), .err_timeout(err_timeout), .err_mismatch(err_mismatch),
        .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_we(fl_we), .fl_re(fl_re),
        .fl_rdata(fl_rdata)
    );

    typedef struct packed {
        logic        erase;
        logic        dpoll;
        logic [15:0] addr;
        logic [15:0] data;
        logic [7:0]  busy;
        logic        tog;
        logic        b7m;
        logic [15:0] corrupt;
        logic        stuck;
        logic        exp_mis;
        logic        exp_tmo;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 16'h1234, 16'hA5C3, 8'd5, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0},
        '{1'b0, 1'b1, 16'h3FFF, 16'h0080, 8'd7, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0},
        '{1'b0, 1'b1, 16'h8001, 16'h1234, 8'd3, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0},
        '{1'b1, 1'b0, 16'h0000, 16'hFFFF, 8'd9, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0},
        '{1'b1, 1'b1, 16'h2000, 16'hFFFF, 8'd6, 1'b1, 1'b1, 16'h0000, 1'b0, 1'b0, 1'b0},
        '{1'b0, 1'b0, 16'h4444, 16'h00FF, 8'd2, 1'b1, 1'b0, 16'h0100, 1'b0, 1'b1, 1'b0},
        '{1'b0, 1'b1, 16'h7777, 16'h5A5A, 8'd0, 1'b1, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b1},
        '{1'b1, 1'b1, 16'h9000, 16'hFFFF, 8'd0, 1'b1, 1'b1, 16'h0000, 1'b1, 1'b0, 1'b1},
        '{1'b0, 1'b1, 16'hFFFF, 16'h0001, 8'd0, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0},
        '{1'b0, 1'b0, 16'h0002, 16'hFFFE, 8'd0, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0}
    };

    int checks = 0;
    int errors = 0;

    // device model configuration, written only by the stimulus tasks
    vec_t cur = '0;

    // device model state, written only by the model process
    int          wcnt = 0;
    int          reads = 0;
    int          bad_w = 0;
    int          bad_ra = 0;
    int          overlap = 0;
    int          run = 0;
    int          busy_left = 0;
    logic        tgl = 1'b0;
    logic [31:0] wlog [6];

    int   nwr;
    logic dev_busy;
    logic exp_b7;

    always_comb begin
        nwr      = cur.erase ? 6 : 4;
        dev_busy = cur.stuck || (busy_left != 0);
        exp_b7   = cur.erase ? 1'b1 : cur.data[7];
        if (dev_busy) begin
            fl_rdata    = '0;
            fl_rdata[6] = cur.tog & tgl;
            fl_rdata[7] = cur.b7m ? exp_b7 : ~exp_b7;
        end else begin
            fl_rdata = (cur.erase ? 16'hFFFF : cur.data) ^ cur.corrupt;
        end
    end

    always @(posedge clk) begin
        if (req_valid && req_ready) begin
            wcnt <= 0; reads <= 0; bad_w <= 0; bad_ra <= 0; overlap <= 0;
            run <= 0; busy_left <= 0; tgl <= 1'b0;
        end else begin
            if (fl_we && fl_re) overlap <= overlap + 1;
            if (fl_we) begin
                run <= run + 1;
                if (run == 0) begin
                    if (wcnt < 6) wlog[wcnt] <= {fl_addr, fl_wdata};
                    wcnt <= wcnt + 1;
                    if (wcnt + 1 == nwr) begin
                        busy_left <= int'(cur.busy);
                        tgl <= 1'b0;
                    end
                end
            end else if (run != 0) begin
                if (run != STRB) bad_w <= bad_w + 1;
                run <= 0;
            end
            if (fl_re) begin
                reads <= reads + 1;
                if (fl_addr != cur.addr) bad_ra <= bad_ra + 1;
                if (dev_busy) tgl <= ~tgl;
                if (!cur.stuck && busy_left > 0) busy_left <= busy_left - 1;
            end
        end
    end

    function automatic logic [31:0] exp_wr(input vec_t v, input int i);
        logic [31:0] r;
        case (i)
            0: r = {16'h5555, 16'h00AA};
            1: r = {16'h2AAA, 16'h0055};
            2: r = {16'h5555, v.erase ? 16'h0080 : 16'h00A0};
            3: r = v.erase ? {16'h5555, 16'h00AA} : {v.addr, v.data};
            4: r = {16'h2AAA, 16'h0055};
            default: r = {16'h5555, 16'h0030};
        endcase
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v);
        int n;
        int rdy_bad;
        string ctag;
        n = 0;
        rdy_bad = 0;
        @(negedge clk);
        cur       = v;
        req_erase = v.erase;
        req_dpoll = v.dpoll;
        req_addr  = v.addr;
        req_data  = v.data;
        req_valid = 1'b1;
        chk(req_ready == 1'b1, "R9", "ready before accept", 32'(req_ready), 32'd1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!(done || err_timeout) && n < 600) begin
            if (req_ready) rdy_bad++;
            @(negedge clk);
            n++;
        end
        chk(n < 600, "R9", "operation ended", 32'(n), 32'd600);
        chk(rdy_bad == 0, "R9", "ready low while busy", 32'(rdy_bad), 32'd0);
        chk(req_ready == 1'b1, "R9", "ready with result", 32'(req_ready), 32'd1);
        chk(wcnt == nwr, v.erase ? "R2" : "R1", "write count", 32'(wcnt), 32'(nwr));
        for (int i = 0; i < nwr; i++) begin
            chk(wlog[i] == exp_wr(v, i), v.erase ? "R2" : "R1",
                $sformatf("write %0d addr/data", i), wlog[i], exp_wr(v, i));
        end
        chk(bad_w == 0, "R3", "strobe width", 32'(bad_w), 32'd0);
        chk(overlap == 0, "R11", "read/write overlap", 32'(overlap), 32'd0);
        chk(bad_ra == 0, "R5", "read address", 32'(bad_ra), 32'd0);
        chk(err_timeout == v.exp_tmo, "R7", "timeout flag", 32'(err_timeout), 32'(v.exp_tmo));
        if (v.exp_tmo) begin
            chk(done == 1'b0, "R7", "no done on timeout", 32'(done), 32'd0);
            chk(reads == PLIM, "R7", "poll reads before timeout", 32'(reads), 32'(PLIM));
        end else begin
            ctag = v.erase ? "R6" : (v.dpoll ? "R5" : "R4");
            chk(done == 1'b1, ctag, "done pulse", 32'(done), 32'd1);
            chk(busy_left == 0, ctag, "no completion while busy", 32'(busy_left), 32'd0);
            chk(err_mismatch == v.exp_mis, "R8", "mismatch flag",
                32'(err_mismatch), 32'(v.exp_mis));
        end
        @(negedge clk);
        chk(!done && !err_timeout && !err_mismatch, "R8", "result is one cycle",
            {29'd0, done, err_timeout, err_mismatch}, 32'd0);
        chk(req_ready == 1'b1, "R9", "ready stays high in idle", 32'(req_ready), 32'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, got hung expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R10: state held in reset
        repeat (3) @(negedge clk);
        chk(req_ready && !fl_we && !fl_re && !done && !err_timeout && !err_mismatch,
            "R10", "outputs in reset",
            {26'd0, req_ready, fl_we, fl_re, done, err_timeout, err_mismatch}, 32'h20);
        rst_n = 1'b1;
        @(negedge clk);

        for (int k = 0; k < NV; k++) begin
            run_vec(VEC[k]);
        end

        // R10: reset in the middle of a write strobe abandons the operation
        @(negedge clk);
        cur       = VEC[0];
        req_erase = 1'b0;
        req_dpoll = 1'b0;
        req_addr  = 16'h0F0F;
        req_data  = 16'h1111;
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        chk(fl_we == 1'b1, "R3", "strobe active mid write", 32'(fl_we), 32'd1);
        rst_n = 1'b0;
        #1;
        chk(!fl_we && !fl_re && req_ready, "R10", "reset mid operation",
            {29'd0, fl_we, fl_re, req_ready}, 32'd1);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (STRB + 2) @(negedge clk);
        chk(!fl_we && req_ready && !done, "R10", "stays idle after reset",
            {29'd0, fl_we, req_ready, done}, 32'd2);

        // R10: full recovery after the abandoned operation
        run_vec(VEC[0]);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule